// File: doc/BRIEF.md
# SPI Slave Command Front-End

This block is the peripheral-side serial interface of an SPI memory-style device. It works in SPI mode 0 only: input bits are taken on the rising serial clock edge, output bits change on the falling edge, and the most significant bit comes first in both directions. The block is always the slave, so the serial clock is only ever an input. The first byte after chip select falls is decoded as a command code. A supported code is handed to the back-end with a one-clock strobe. Every later complete byte is handed over with its own strobe. For read-type commands, bytes supplied by the back-end are shifted out.

An unsupported command code locks the interface until the next chip-select fall. A hold input pauses a transfer without losing the bit position or the decoded command. Serial clock edges seen during the pause shift nothing.

All four serial pins pass through a synchronizer into the system clock domain, and every state change happens on that clock. Chip select high clears the transfer state. The memory array, any status contents and the write timing belong to the back-end.

Top module: `spi_cmd_frontend`

## Requirements
- R1: Bits are taken from SI on the rising SCK edge and presented on SO after the falling SCK edge, most significant bit first in both directions.
- R2: When the first byte after a chip-select fall is one of 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02, cmd_strobe pulses for one clock. cmd_code then holds that byte, and op_active stays high until chip select rises.
- R3: After an accepted command byte, each further group of 8 bits raises data_strobe for exactly one clock, with the assembled byte on data_byte.
- R4: While chip select is high, SO is not driven and SI and SCK are ignored (no strobes). Bit position and command state are cleared, so the next chip-select fall starts a new command byte, even after an aborted partial byte.
- R5: After a first byte outside the set listed in R2, no strobe is raised, op_active stays low and SO is not driven until chip select rises and falls again. The transaction that follows then decodes normally.
- R6: The hold state follows the inverted HOLD input only while SCK is low and keeps its value while SCK is high. SCK edges seen while held shift nothing, and the bit position and command are kept through the pause.
- R7: While held, SO is not driven and the output bit keeps its value. Shifting resumes from the same bit after release.
- R8: SO is driven only for commands 0x05 and 0x03, from the end of the command byte to chip-select rise. tx_byte is captured on the clock edge that raises cmd_strobe or data_strobe, and its bit 7 appears at the next SCK fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data in (SI) |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out value (SO) |
| spi_miso_oe | output | 1 | Output enable for SO; 0 means high impedance |
| cmd_strobe | output | 1 | One-clock pulse when a supported command byte is accepted |
| cmd_code | output | 8 | Accepted command code of the current transaction |
| op_active | output | 1 | A supported command is in progress |
| data_strobe | output | 1 | One-clock pulse per complete byte after the command |
| data_byte | output | 8 | Byte delivered with data_strobe |
| tx_byte | input | 8 | Next byte to shift out, captured with each strobe |

## Verification
A bit counter that slips shows up at the ports within one byte: data_byte is rotated, or a strobe comes a bit early or late. A lockout flag that stays set or is missed shows in the next transaction: strobes appear where none are allowed, or a valid command after reselect is lost. Wrong hold state shows on the next SCK edge inside the pause. A shifted extra bit corrupts the byte being assembled, and SO becomes driven while held. The bench therefore reads every strobe against a per-transaction expectation and watches the enable on every clock while chip select is high.

// File: rtl/spi_fe_pkg.sv
// Package: shared widths and command decoding for the SPI command front-end.
// Assumes 8-bit command and data units.
package spi_fe_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WR_EN   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_DIS  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RD_STAT = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_STAT = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RD_MEM  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WR_MEM  = 8'h02;

    // True when the code belongs to the supported command set.
    function automatic logic op_known(input logic [BYTE_W-1:0] code);
        return (code == OP_WR_EN)   || (code == OP_WR_DIS) ||
               (code == OP_RD_STAT) || (code == OP_WR_STAT) ||
               (code == OP_RD_MEM)  || (code == OP_WR_MEM);
    endfunction

    // True when the command returns data on the serial output.
    function automatic logic op_reads(input logic [BYTE_W-1:0] code);
        return (code == OP_RD_STAT) || (code == OP_RD_MEM);
    endfunction
endpackage

// File: rtl/spi_fe_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL sets the idle level per bit.
module spi_fe_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop rank of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else if (g == 0) stage[g] <= d;
                else stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
// Pause tracker: follows the inverted hold pin only while SCK is low,
// keeps its value while SCK is high, clears when deselected.
// Assumes all inputs are already synchronized to clk.
module spi_fe_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic held
);
    // Update the pause state.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) held <= 1'b0;
        else if (!sck_s)      held <= !hold_n_s;
    end
endmodule

// File: rtl/spi_fe_engine.sv
// Shift engine: detects SCK edges, assembles input bytes on rises,
// decodes the first byte, handles lockout, and shifts output on falls.
// Assumes synchronized pins; chip select high clears the transfer state.
module spi_fe_engine
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              held,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              lockout,
    output logic              op_valid,
    output logic [BYTE_W-1:0] op_code,
    output logic              cmd_stb,
    output logic              dat_stb,
    output logic [BYTE_W-1:0] dat_byte,
    output logic              miso
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_next;
    logic              sck_rise, sck_fall, shift_ok;

    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;
    assign shift_ok = !cs_n_s && !held && !lockout;
    assign rx_next  = {rx_sr, mosi_s};

    // Delayed SCK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Input side: bit count, byte assembly, command decode, lockout.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            lockout  <= 1'b0;
            op_valid <= 1'b0;
            op_code  <= '0;
            cmd_stb  <= 1'b0;
            dat_stb  <= 1'b0;
            dat_byte <= '0;
        end else begin
            cmd_stb <= 1'b0;
            dat_stb <= 1'b0;
            if (sck_rise && shift_ok) begin
                rx_sr   <= rx_next[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    if (op_valid) begin
                        dat_stb  <= 1'b1;
                        dat_byte <= rx_next;
                    end else if (op_known(rx_next)) begin
                        op_valid <= 1'b1;
                        op_code  <= rx_next;
                        cmd_stb  <= 1'b1;
                    end else begin
                        lockout  <= 1'b1;
                    end
                end
            end
        end
    end

    // Output side: load at byte boundary, shift one bit per SCK fall.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (sck_rise && shift_ok && bit_cnt == LAST_BIT) begin
            tx_sr <= tx_byte;
        end else if (sck_fall && shift_ok) begin
            miso  <= tx_sr[BYTE_W-1];
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_cmd_frontend.sv
// Top: SPI mode-0 slave command front-end. Synchronizes the serial pins,
// tracks the hold pause, runs the shift engine and drives the SO enable.
// Assumes clk is several times faster than SCK.
module spi_cmd_frontend
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              cmd_strobe,
    output logic [BYTE_W-1:0] cmd_code,
    output logic              op_active,
    output logic              data_strobe,
    output logic [BYTE_W-1:0] data_byte,
    input  logic [BYTE_W-1:0] tx_byte
);
    logic [3:0] pins_s;
    logic       cs_n_s, sck_s, mosi_s, hold_n_s;
    logic       held_q, lock_q;

    spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) i_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({spi_hold_n, spi_mosi, spi_sck, spi_cs_n}),
        .q (pins_s)
    );
    assign {hold_n_s, mosi_s, sck_s, cs_n_s} = pins_s;

    spi_fe_hold i_hold (
        .clk (clk),
        .rst_n (rst_n),
        .cs_n_s (cs_n_s),
        .sck_s (sck_s),
        .hold_n_s (hold_n_s),
        .held (held_q)
    );

    spi_fe_engine i_eng (
        .clk (clk),
        .rst_n (rst_n),
        .cs_n_s (cs_n_s),
        .sck_s (sck_s),
        .mosi_s (mosi_s),
        .held (held_q),
        .tx_byte (tx_byte),
        .lockout (lock_q),
        .op_valid (op_active),
        .op_code (cmd_code),
        .cmd_stb (cmd_strobe),
        .dat_stb (data_strobe),
        .dat_byte (data_byte),
        .miso (spi_miso)
    );

    assign spi_miso_oe = !cs_n_s && op_active && op_reads(cmd_code) &&
                         !held_q && !lock_q;
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
// Checker for spi_cmd_frontend: temporal properties on ports and the
// internal hold, lockout and synchronized chip-select state.
module spi_cmd_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_s,
    input logic       held,
    input logic       lockout,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       cmd_strobe,
    input logic       data_strobe,
    input logic       op_active
);
    AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !spi_miso_oe);                                       // R4
    AST_HELD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !spi_miso_oe);                                         // R7
    AST_HELD_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_n_s) |=> $stable(spi_miso));                      // R7
    AST_LOCKOUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> (!cmd_strobe && !data_strobe && !spi_miso_oe && !op_active)); // R5
    AST_CMD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (op_active && !$past(op_active)));               // R2
    AST_DATA_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe |-> (op_active && $past(op_active)));               // R3
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_strobe && data_strobe));                                  // R3
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk i_chk (
    .clk (clk),
    .rst_n (rst_n),
    .cs_n_s (cs_n_s),
    .held (held_q),
    .lockout (lock_q),
    .spi_miso (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .cmd_strobe (cmd_strobe),
    .data_strobe (data_strobe),
    .op_active (op_active)
);

// File: tb/test_spi_cmd_frontend.sv
// Bench: drives SPI mode-0 transactions slowly against a 125 MHz clock,
// keeps queues of expected command and data bytes, compares every clock.
module test_spi_cmd_frontend;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic       miso, miso_oe, cmd_strobe, op_active, data_strobe;
    logic [7:0] cmd_code, data_byte;
    logic [7:0] tx_byte = 8'h00;

    int checks = 0;
    int errors = 0;
    int cs_hi_cnt = 0;
    logic [7:0] exp_cmd_q[$];
    logic [7:0] exp_dat_q[$];
    int cmd_seen = 0;
    int dat_seen = 0;

    always #4 clk = ~clk;

    spi_cmd_frontend i_spi_cmd_frontend (
        .clk (clk), .rst_n (rst_n),
        .spi_cs_n (cs_n), .spi_sck (sck), .spi_mosi (mosi), .spi_hold_n (hold_n),
        .spi_miso (miso), .spi_miso_oe (miso_oe),
        .cmd_strobe (cmd_strobe), .cmd_code (cmd_code), .op_active (op_active),
        .data_strobe (data_strobe), .data_byte (data_byte), .tx_byte (tx_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the expected strobe queues and deselect rule.
    always @(negedge clk) begin
        if (rst_n) begin
            cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
            if (cs_hi_cnt > 5) check("R4 oe while deselected", miso_oe, 0);
            if (cmd_strobe) begin
                cmd_seen++;
                if (exp_cmd_q.size() == 0) check("R2/R5 unexpected cmd_strobe", cmd_code, 0);
                else check("R2 cmd_code", cmd_code, exp_cmd_q.pop_front());
            end
            if (data_strobe) begin
                dat_seen++;
                if (exp_dat_q.size() == 0) check("R3/R5 unexpected data_strobe", data_byte, 0);
                else check("R3 R1 data_byte", data_byte, exp_dat_q.pop_front());
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic m, output logic o);
        mosi = b;
        wait_clk(HALF);
        m = miso;
        o = miso_oe;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic spi_xfer(input logic [7:0] mo, output logic [7:0] mi, output logic oe_all);
        logic m, o;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(mo[i], m, o);
            mi[i] = m;
            oe_all = oe_all & o;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic queues_empty(input string req);
        wait_clk(4);
        check({req, " cmd queue drained"}, exp_cmd_q.size(), 0);
        check({req, " data queue drained"}, exp_dat_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] mi;
        logic oe_all, m, o;
        int c0, d0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check("R4 reset oe", miso_oe, 0);
        check("R2 reset op_active", op_active, 0);
        check("R3 reset strobes", {cmd_strobe, data_strobe}, 0);

        // R2: single-byte command, no output drive (R8).
        exp_cmd_q.push_back(8'h06);
        sel();
        spi_xfer(8'h06, mi, oe_all);
        wait_clk(4);
        check("R2 op_active after write-enable", op_active, 1);
        check("R8 no drive for non-read command", miso_oe, 0);
        desel();
        check("R2 op_active cleared on deselect", op_active, 0);
        queues_empty("R2");

        // R3 R1: write command followed by three data bytes, MSB first.
        exp_cmd_q.push_back(8'h02);
        exp_dat_q.push_back(8'hA5); exp_dat_q.push_back(8'h5A); exp_dat_q.push_back(8'hC3);
        sel();
        spi_xfer(8'h02, mi, oe_all);
        spi_xfer(8'hA5, mi, oe_all);
        spi_xfer(8'h5A, mi, oe_all);
        spi_xfer(8'hC3, mi, oe_all);
        check("R8 no drive during write data", oe_all, 0);
        desel();
        queues_empty("R3");

        // R8 R1: status read returns the back-end byte.
        tx_byte = 8'hB6;
        exp_cmd_q.push_back(8'h05);
        exp_dat_q.push_back(8'h00);
        sel();
        spi_xfer(8'h05, mi, oe_all);
        check("R8 no drive during command byte", oe_all, 0);
        spi_xfer(8'h00, mi, oe_all);
        check("R8 R1 status byte out", mi, 8'hB6);
        check("R8 driven during read byte", oe_all, 1);
        desel();
        queues_empty("R8");

        // R5: unsupported command locks out until reselect.
        c0 = cmd_seen; d0 = dat_seen;
        sel();
        spi_xfer(8'hAB, mi, oe_all);
        spi_xfer(8'h06, mi, oe_all);
        spi_xfer(8'h03, mi, oe_all);
        check("R5 no drive after bad command", oe_all, 0);
        check("R5 op_active stays low", op_active, 0);
        desel();
        check("R5 no command strobe", cmd_seen - c0, 0);
        check("R5 no data strobe", dat_seen - d0, 0);
        // R5: reselect decodes normally again.
        tx_byte = 8'h3C;
        exp_cmd_q.push_back(8'h03);
        exp_dat_q.push_back(8'h12);
        sel();
        spi_xfer(8'h03, mi, oe_all);
        spi_xfer(8'h12, mi, oe_all);
        check("R5 read after reselect", mi, 8'h3C);
        desel();
        queues_empty("R5");

        // R4: aborted partial byte, then SCK/SI activity while deselected.
        c0 = cmd_seen;
        sel();
        for (int i = 0; i < 4; i++) spi_bit(1'b1, m, o);
        desel();
        for (int i = 0; i < 10; i++) spi_bit(i[0], m, o);
        wait_clk(HALF);
        check("R4 no strobe while deselected", cmd_seen - c0, 0);
        exp_cmd_q.push_back(8'h04);
        sel();
        spi_xfer(8'h04, mi, oe_all);
        desel();
        queues_empty("R4");

        // R6: hold mid-byte with SCK toggling; bits of the byte kept.
        exp_cmd_q.push_back(8'h02);
        exp_dat_q.push_back(8'h9E);
        sel();
        spi_xfer(8'h02, mi, oe_all);
        for (int i = 7; i >= 4; i--) spi_bit(8'h9E >> i, m, o);
        wait_clk(4);
        hold_n = 1'b0;
        wait_clk(HALF);
        d0 = dat_seen;
        for (int i = 0; i < 6; i++) spi_bit(1'b0, m, o);
        wait_clk(4);
        check("R6 no strobe during hold", dat_seen - d0, 0);
        check("R6 command kept during hold", op_active, 1);
        hold_n = 1'b1;
        wait_clk(HALF);
        for (int i = 3; i >= 0; i--) spi_bit(8'h9E >> i, m, o);
        desel();
        queues_empty("R6");

        // R6: hold pulse only while SCK high has no effect.
        exp_cmd_q.push_back(8'h01);
        exp_dat_q.push_back(8'h6D);
        sel();
        spi_xfer(8'h01, mi, oe_all);
        for (int i = 7; i >= 0; i--) begin
            mosi = 1'(8'h6D >> i);
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(1);
            if (i == 5) hold_n = 1'b0;
            wait_clk(4);
            hold_n = 1'b1;
            wait_clk(HALF - 5);
            sck = 1'b0;
        end
        desel();
        queues_empty("R6 high-phase hold");

        // R7: hold during a read data byte; SO undriven, then resumes.
        tx_byte = 8'hE1;
        exp_cmd_q.push_back(8'h03);
        exp_dat_q.push_back(8'h00);
        sel();
        spi_xfer(8'h03, mi, oe_all);
        mi = '0;
        for (int i = 7; i >= 4; i--) begin spi_bit(1'b0, m, o); mi[i] = m; end
        wait_clk(4);
        hold_n = 1'b0;
        wait_clk(HALF);
        check("R7 no drive while held", miso_oe, 0);
        for (int i = 0; i < 3; i++) begin
            spi_bit(1'b1, m, o);
            check("R7 no drive on SCK while held", o, 0);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
        for (int i = 3; i >= 0; i--) begin spi_bit(1'b0, m, o); mi[i] = m; end
        check("R7 read byte intact across hold", mi, 8'hE1);
        check("R7 driven after release", o, 1);
        desel();
        queues_empty("R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule